// File: doc/BRIEF.md
# Serial Receive Queue Controller

This block sits behind a serial receiver and places each received 9-bit frame into a 16-entry circular queue. The queue is treated as two halves. The first half is entries 0 to 7 and the second half is entries 8 to 15. Each half has its own full flag and its own interrupt enable. Software can therefore empty one half while the receiver fills the other. A store pointer names the slot for the next good frame.

If a frame arrives for a half that software has not yet released, the block raises an overrun flag and switches itself off. A frame with a framing or parity error is never stored. Instead, that error is latched, and storage stops until software clears the error.

Flags are cleared through a small register bus. Software reads the status register and then writes back zeros. The noise and idle flags are cleared differently: software reads status and then reads a queue entry. Writing the enable bit from 0 to 1 re-initializes the queue.

Register map: address 0 is control, address 1 is status, and addresses 16 to 31 hold queue entries 0 to 15. Control bits are: bit 0 queue enable, bit 1 first-half interrupt enable, bit 2 second-half interrupt enable. Status bits are: bit 0 first-half full, bit 1 second-half full, bit 2 overrun, bit 3 framing error, bit 4 parity error, bit 5 noise, bit 6 idle. Status bits 11:8 hold the store pointer. All other bits read as zero.

Top module: `rxq_ctrl`

## Requirements
- R1: After reset, control and status both read 0, every flag is clear, the pointer is 0 and `irq` is low.
- R2: A stored frame goes into the entry named by the pointer. The pointer then advances by one and wraps from 15 to 0. A read of address 16+i returns entry i zero-extended to 16 bits. Queue reads never move the pointer.
- R3: A frame with `rx_fe` or `rx_pe` set is never stored. The matching status bit (3 for framing, 4 for parity) is set. The pointer keeps the slot that frame would have used. Later frames are ignored while bit 3 or bit 4 is set.
- R4: Status bit 0 sets when entry 7 is filled, and status bit 1 sets when entry 15 is filled. Sixteen error-free stores after a re-init leave both bits set and the pointer at 0.
- R5: `irq` equals (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2).
- R6: Suppose a frame arrives while the pointer's half (pointer bit 3) has its full flag set. Then the frame is not stored, status bit 2 sets, and control bit 0 is cleared by hardware.
- R7: A frame is acted on only when all of these hold: control bit 0 is set, `rx_en` is high, `sb_ovr` is low, and status bits 2, 3 and 4 are clear. Any other frame leaves status and the queue unchanged.
- R8: Status bits 0 to 4 each clear only through a two-step sequence. First, a status read must see the bit set. Then the next status write must carry 0 in that bit. A zero write without that read, or a write of 1, leaves the bit unchanged.
- R9: A frame stored with `rx_noise` high sets status bit 5. An `rx_idle` pulse sets status bit 6. Each of these bits clears when a status read sees it set and is followed by a queue entry read.
- R10: A control write with bit 0 = 1 while the queue is disabled resets the pointer to 0 and clears status bits 0 to 2. The stored entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_data | input | 9 | Received frame |
| rx_fe | input | 1 | Framing error for this frame |
| rx_pe | input | 1 | Parity error for this frame |
| rx_noise | input | 1 | Noise detected on this frame |
| rx_idle | input | 1 | Pulse: the line has gone idle |
| rx_en | input | 1 | Receiver enable |
| sb_ovr | input | 1 | Single-buffer overrun flag of the receiver |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Half-full interrupt |

## Verification
A pointer that skips a slot or fails to advance puts the next frame at the wrong queue address. It also moves the half-full flags, and the next status read shows the wrong pointer field. A wrong value in a flag register or in a clear-arming bit shows up at `irq` and in the status word. It appears on the first read or frame after the faulty edge, at the latest one bus access later. The bench keeps a reference queue model that is updated by every bus access and frame. It compares every read and the interrupt after every operation, so a fault is reported within one operation of when it appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // register addresses (low half of the address space)
   localparam int CTRL_ADDR   = 0;
   localparam int STAT_ADDR   = 1;
   // control bit positions
   localparam int CT_QEN      = 0;
   localparam int CT_LO_IE    = 1;
   localparam int CT_HI_IE    = 2;
   // status field positions
   localparam int ST_NFLAGS   = 7;
   localparam int ST_PTR_LSB  = 8;

   // status flags, bit 0 = first-half full ... bit 6 = idle
   typedef struct packed {
      logic idle;
      logic nf;
      logic pe;
      logic fe;
      logic ovr;
      logic hi;
      logic lo;
   } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PW-1:0]     widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PW-1:0]     ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_hold
      // R2: an entry changes only when it is the write target
      entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && widx == PW'(g)) |=> $stable(mem[g]));
   end
endmodule

// File: rtl/rxq_fill.sv
module rxq_fill #(
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_v,
   input  logic          frame_fe,
   input  logic          frame_pe,
   input  logic          frame_nf,
   input  logic          rx_en,
   input  logic          sb_ovr,
   input  logic          err_hold,
   input  logic          ctrl_wr,
   input  logic          ctrl_qen,
   input  logic [1:0]    clr_half,
   input  logic          clr_ovr,
   output logic          qen,
   output logic [PW-1:0] ptr,
   output logic [1:0]    half_full,
   output logic          ovr,
   output logic          we,
   output logic          rec_fe,
   output logic          rec_pe,
   output logic          rec_nf
);
   logic active, take, bad, blocked, reinit, at_half_end, cur_half;

   assign active      = qen && rx_en && !ovr && !sb_ovr && !err_hold;
   assign take        = frame_v && active;
   assign bad         = take && (frame_fe || frame_pe);
   assign cur_half    = ptr[PW-1];
   assign blocked     = take && !bad && half_full[cur_half];
   assign we          = take && !bad && !blocked;
   assign reinit      = ctrl_wr && ctrl_qen && !qen;
   assign at_half_end = &ptr[PW-2:0];

   assign rec_fe = bad && frame_fe;
   assign rec_pe = bad && frame_pe;
   assign rec_nf = we && frame_nf;

   always_ff @(posedge clk) begin
      if (!rst_n)        ptr <= '0;
      else if (reinit)   ptr <= '0;
      else if (we)       ptr <= ptr + 1'b1;
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
         if (!rst_n)                                   half_full[h] <= 1'b0;
         else if (reinit)                              half_full[h] <= 1'b0;
         else if (we && cur_half == h && at_half_end)  half_full[h] <= 1'b1;
         else if (clr_half[h])                         half_full[h] <= 1'b0;
      end
      // R8: a half flag drops only through the clear sequence or a re-init
      half_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(half_full[h]) |-> $past(clr_half[h]) || $past(reinit));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ovr <= 1'b0;
      else if (reinit)   ovr <= 1'b0;
      else if (blocked)  ovr <= 1'b1;
      else if (clr_ovr)  ovr <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        qen <= 1'b0;
      else if (blocked)  qen <= 1'b0;
      else if (ctrl_wr)  qen <= ctrl_qen;
   end

   // R2: every store advances the pointer by exactly one
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ptr == PW'($past(ptr) + 1'b1));
   // R3: an errored frame never moves the pointer
   err_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_v && (frame_fe || frame_pe) && !reinit) |=> $stable(ptr));
   // R6: overrun always comes with the queue switched off
   ovr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> !qen);
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
   import rxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_fe,
   input  logic       set_pe,
   input  logic       set_nf,
   input  logic       set_idle,
   input  logic       stat_rd,
   input  logic       stat_wr,
   input  logic [4:0] wbits,
   input  logic       q_rd,
   input  rxq_flags_t cur,
   output logic       fe,
   output logic       pe,
   output logic       nf,
   output logic       idle,
   output logic [1:0] clr_half,
   output logic       clr_ovr
);
   rxq_flags_t arm;
   logic [4:0] clr_w;
   logic       clr_nf, clr_idle;

   // write-side clears: armed by an earlier status read, released by a 0 bit
   assign clr_w    = stat_wr ? (arm[4:0] & ~wbits) : 5'b0;
   assign clr_half = clr_w[1:0];
   assign clr_ovr  = clr_w[2];
   assign clr_nf   = q_rd && arm.nf;
   assign clr_idle = q_rd && arm.idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm <= '0;
      end else if (stat_rd) begin
         arm <= cur;
      end else begin
         if (stat_wr) arm[4:0] <= '0;
         if (q_rd) begin
            arm.nf   <= 1'b0;
            arm.idle <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fe <= 1'b0; pe <= 1'b0; nf <= 1'b0; idle <= 1'b0;
      end else begin
         if (set_fe)        fe <= 1'b1;
         else if (clr_w[3]) fe <= 1'b0;
         if (set_pe)        pe <= 1'b1;
         else if (clr_w[4]) pe <= 1'b0;
         if (set_nf)        nf <= 1'b1;
         else if (clr_nf)   nf <= 1'b0;
         if (set_idle)      idle <= 1'b1;
         else if (clr_idle) idle <= 1'b0;
      end
   end

   // R9: noise flag falls only on a queue read
   nf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nf) |-> $past(q_rd));
   // R8: framing flag falls only on a status write
   fe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe) |-> $past(stat_wr));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   parameter int BUS_W  = 16,
   localparam int PW    = $clog2(DEPTH),
   localparam int AW    = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_fe,
   input  logic              rx_pe,
   input  logic              rx_noise,
   input  logic              rx_idle,
   input  logic              rx_en,
   input  logic              sb_ovr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_ctrl: DEPTH must be a power of two, at least 4");
   end
   if (DATA_W > BUS_W || BUS_W < ST_PTR_LSB + PW) begin : g_bad_bus
      $error("rxq_ctrl: BUS_W too narrow for the data or status word");
   end

   logic              stat_rd, stat_wr, ctrl_wr, q_rd, is_q;
   logic              qen, ovr, we, rec_fe, rec_pe, rec_nf;
   logic              fe, pe, nf, idle, clr_ovr;
   logic              lo_ie, hi_ie;
   logic [1:0]        half_full, clr_half;
   logic [PW-1:0]     ptr;
   logic [DATA_W-1:0] q_data;
   rxq_flags_t        flags;
   logic              wdata_unused;

   assign is_q    = bus_addr[AW-1];
   assign stat_rd = bus_rd && bus_addr == AW'(STAT_ADDR);
   assign stat_wr = bus_wr && bus_addr == AW'(STAT_ADDR);
   assign ctrl_wr = bus_wr && bus_addr == AW'(CTRL_ADDR);
   assign q_rd    = bus_rd && is_q;
   assign wdata_unused = ^bus_wdata[BUS_W-1:ST_NFLAGS];

   assign flags = '{idle: idle, nf: nf, pe: pe, fe: fe, ovr: ovr,
                    hi: half_full[1], lo: half_full[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_ie <= 1'b0;
         hi_ie <= 1'b0;
      end else if (ctrl_wr) begin
         lo_ie <= bus_wdata[CT_LO_IE];
         hi_ie <= bus_wdata[CT_HI_IE];
      end
   end

   rxq_fill #(.DEPTH(DEPTH)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .frame_v(rx_valid), .frame_fe(rx_fe), .frame_pe(rx_pe), .frame_nf(rx_noise),
      .rx_en(rx_en), .sb_ovr(sb_ovr), .err_hold(fe || pe),
      .ctrl_wr(ctrl_wr), .ctrl_qen(bus_wdata[CT_QEN]),
      .clr_half(clr_half), .clr_ovr(clr_ovr),
      .qen(qen), .ptr(ptr), .half_full(half_full), .ovr(ovr), .we(we),
      .rec_fe(rec_fe), .rec_pe(rec_pe), .rec_nf(rec_nf)
   );

   rxq_stat u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_fe(rec_fe), .set_pe(rec_pe), .set_nf(rec_nf), .set_idle(rx_idle),
      .stat_rd(stat_rd), .stat_wr(stat_wr), .wbits(bus_wdata[4:0]), .q_rd(q_rd),
      .cur(flags), .fe(fe), .pe(pe), .nf(nf), .idle(idle),
      .clr_half(clr_half), .clr_ovr(clr_ovr)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(we), .widx(ptr), .wdata(rx_data),
      .ridx(bus_addr[PW-1:0]), .rdata(q_data)
   );

   always_comb begin
      bus_rdata = '0;
      if (is_q) begin
         bus_rdata[DATA_W-1:0] = q_data;
      end else if (bus_addr == AW'(CTRL_ADDR)) begin
         bus_rdata[CT_QEN]   = qen;
         bus_rdata[CT_LO_IE] = lo_ie;
         bus_rdata[CT_HI_IE] = hi_ie;
      end else if (bus_addr == AW'(STAT_ADDR)) begin
         bus_rdata[ST_NFLAGS-1:0]      = flags;
         bus_rdata[ST_PTR_LSB +: PW]   = ptr;
      end
   end

   assign irq = (half_full[0] && lo_ie) || (half_full[1] && hi_ie);

   // R5: the interrupt needs a full half behind it
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (half_full != 2'b00));
   // R2: queue reads leave the pointer alone
   qrd_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_rd && !rx_valid && !bus_wr) |=> $stable(ptr));
endmodule

// File: tb/rxq_ctrl_bench.sv
`timescale 1ns/1ps
module rxq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 0, rx_fe = 0, rx_pe = 0, rx_noise = 0, rx_idle = 0;
   logic        rx_en = 1, sb_ovr = 0;
   logic [8:0]  rx_data = '0;
   logic        bus_rd = 0, bus_wr = 0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   always #2 clk = ~clk;

   rxq_ctrl u_rxq_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_fe(rx_fe), .rx_pe(rx_pe), .rx_noise(rx_noise), .rx_idle(rx_idle),
      .rx_en(rx_en), .sb_ovr(sb_ovr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int errors = 0, checks = 0;
   bit done = 0;

   // reference model
   logic [8:0] mq [16];
   logic [3:0] mp;
   logic [6:0] mf;     // 0 lo,1 hi,2 ovr,3 fe,4 pe,5 nf,6 idle
   logic [6:0] marm;
   logic       mqen;
   logic [1:0] mie;

   function automatic logic [15:0] exp_stat();
      return {4'b0, mp, 1'b0, mf};
   endfunction
   function automatic logic [15:0] exp_ctrl();
      return {13'b0, mie, mqen};
   endfunction
   function automatic logic exp_irq();
      return (mf[0] && mie[0]) || (mf[1] && mie[1]);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_irq(input string req);
      check(req, {15'b0, irq}, {15'b0, exp_irq()});
   endtask

   task automatic frame(input logic [8:0] d, input logic fe, input logic pe, input logic nf);
      logic act;
      @(negedge clk);
      rx_valid = 1; rx_data = d; rx_fe = fe; rx_pe = pe; rx_noise = nf;
      @(posedge clk); #1;
      rx_valid = 0; rx_fe = 0; rx_pe = 0; rx_noise = 0;
      act = mqen && rx_en && !mf[2] && !sb_ovr && !mf[3] && !mf[4];
      if (act) begin
         if (fe || pe) begin
            mf[3] = mf[3] | fe; mf[4] = mf[4] | pe;
         end else if (mf[mp[3]]) begin
            mf[2] = 1; mqen = 0;
         end else begin
            mq[mp] = d;
            if (mp == 4'd7)  mf[0] = 1;
            if (mp == 4'd15) mf[1] = 1;
            mp = mp + 1'b1;
            if (nf) mf[5] = 1;
         end
      end
   endtask

   task automatic rd(input logic [4:0] a, input string req);
      logic [15:0] v, e;
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      #1 v = bus_rdata;
      if (a[4]) e = {7'b0, mq[a[3:0]]};
      else if (a == 5'd0) e = exp_ctrl();
      else if (a == 5'd1) e = exp_stat();
      else e = '0;
      check(req, v, e);
      @(posedge clk); #1;
      bus_rd = 0;
      if (a == 5'd1) marm = mf;
      else if (a[4]) begin
         if (marm[5]) mf[5] = 0;
         if (marm[6]) mf[6] = 0;
         marm[6:5] = 0;
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] w);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = w;
      @(posedge clk); #1;
      bus_wr = 0;
      if (a == 5'd1) begin
         for (int i = 0; i < 5; i++) if (marm[i] && !w[i]) mf[i] = 0;
         marm[4:0] = 0;
      end else if (a == 5'd0) begin
         if (w[0] && !mqen) begin mp = 0; mf[2:0] = 0; end
         mqen = w[0]; mie = w[2:1];
      end
   endtask

   task automatic idle_pulse();
      @(negedge clk); rx_idle = 1;
      @(posedge clk); #1; rx_idle = 0;
      mf[6] = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      for (int i = 0; i < 16; i++) mq[i] = '0;
      mp = 0; mf = 0; marm = 0; mqen = 0; mie = 0;
      seed = $urandom(32'd7013);
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      chk_irq("R1");
      rd(5'd1, "R1");
      rd(5'd0, "R1");
      // R7 disabled queue ignores frames
      frame(9'h155, 0, 0, 0);
      rd(5'd1, "R7");
      // R4 first half, R5 interrupt
      wr(5'd0, 16'h0007);
      for (int i = 0; i < 8; i++) frame(9'(i * 37 + 1), 0, 0, 0);
      chk_irq("R5");
      // R8 zero write without prior read keeps the flag
      wr(5'd1, 16'h0000);
      rd(5'd1, "R8");
      for (int i = 8; i < 16; i++) frame(9'(i * 37 + 1), 0, 0, 0);
      rd(5'd1, "R4");
      rd(5'd16, "R2");
      rd(5'd31, "R2");
      rd(5'd1, "R2");
      // R5 masked interrupt
      wr(5'd0, 16'h0001);
      chk_irq("R5");
      // R6 overrun
      frame(9'h1aa, 0, 0, 0);
      rd(5'd0, "R6");
      rd(5'd1, "R6");
      // R10 re-init keeps data
      wr(5'd0, 16'h0001);
      rd(5'd1, "R10");
      rd(5'd19, "R10");
      // R9 noise stored and cleared
      frame(9'h0f0, 0, 0, 1);
      rd(5'd1, "R9");
      rd(5'd16, "R9");
      rd(5'd1, "R9");
      // R3 errored frame
      frame(9'h111, 1, 0, 0);
      rd(5'd1, "R3");
      frame(9'h122, 0, 0, 0);
      rd(5'd1, "R3");
      // R8 clear with 1 keeps, then read+0 clears
      wr(5'd1, 16'h0008);
      rd(5'd1, "R8");
      wr(5'd1, 16'h0000);
      rd(5'd1, "R8");
      // R7 receiver off and single-buffer overrun
      rx_en = 0; frame(9'h133, 0, 0, 0); rx_en = 1;
      sb_ovr = 1; frame(9'h144, 0, 0, 0); sb_ovr = 0;
      rd(5'd1, "R7");
      // R9 idle
      idle_pulse();
      rd(5'd1, "R9");
      rd(5'd20, "R9");
      rd(5'd1, "R9");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         int unsigned r;
         r = $urandom % 100;
         if (r < 45) frame(9'($urandom), ($urandom % 40) == 0, ($urandom % 40) == 0,
                           ($urandom % 8) == 0);
         else if (r < 60) rd(5'd1, "R8");
         else if (r < 72) wr(5'd1, 16'($urandom) & 16'h007f & 16'($urandom));
         else if (r < 84) rd(5'(16 + ($urandom % 16)), "R2");
         else if (r < 92) begin
            if ($urandom % 2) wr(5'd0, 16'h0000);
            wr(5'd0, {13'b0, 3'($urandom) | 3'b001});
         end
         else if (r < 95) idle_pulse();
         else if (r < 97) rd(5'd0, "R6");
         else begin
            @(negedge clk);
            rx_en  = ($urandom % 4) != 0;
            sb_ovr = ($urandom % 5) == 0;
         end
         chk_irq("R5");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule